// File: doc/BRIEF.md
# Texel Prefetch Rasterizer Front End

This block hides texture fetch latency by splitting pixel walking into two stages with a deep queue between them. The front stage walks a horizontal span one pixel per cycle. For each pixel it forms the texel address, looks the address up in a small direct-mapped line table, and on a miss sends a line fill request at once. It then pushes the pixel's coordinates and address into the queue. Each address is computed only once, and the back stage reuses it from the queue.

The back stage looks only at the head of the queue. It pops the head as soon as the line that entry references has been filled, and it emits a pixel record one cycle later. Every line carries a count of queued entries that point at it. A line whose count is not zero cannot be replaced, so a fill cannot land on data that a waiting pixel still needs. Fill completions come back from the memory side and name the line they complete.

Top module: `pq_prefetch_raster`

## Requirements
- R1: After reset, `spanBusy`, `reqValid` and `pixValid` are 0, and every line-table entry is empty, so the first access to any line misses.
- R2: `spanStart` loads a span only while `spanBusy` is 0 and `spanLen` is nonzero. A pulse while busy is ignored and does not change the pixel stream in progress.
- R3: Pixel i of a span (i = 0..spanLen-1) is emitted with x = spanX+i, y = spanY, and address = (texBase + i*texStep) mod 2^16. Pixels come out in walk order and are never reordered across spans.
- R4: Line address = texel address >> 4. When the line is not present in the table, the walker issues exactly one request (`reqValid`, `reqLine`) for it. When the line is present, pending or filled, no request is issued.
- R5: The table has 8 direct-mapped sets, selected by line[2:0]. A miss on a set whose current line is still referenced by any queued pixel stalls the walker until those references drain.
- R6: The queue holds 512 entries. Apart from R5, the walker stalls only when the queue is full, so a span longer than 512 pixels stays busy until fills let the head drain.
- R7: The head entry leaves the queue only after its line has been filled. A `fillValid` naming line L marks set L[2:0] filled, and only if that set is pending.
- R8: While the head lines are filled, the back stage emits one pixel per cycle with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| spanStart | input | 1 | Begin a span (accepted when idle) |
| spanX | input | 11 | First pixel x |
| spanY | input | 11 | Span row |
| spanLen | input | 10 | Pixel count |
| texBase | input | 16 | Texel address of the first pixel |
| texStep | input | 16 | Texel address increment per pixel |
| spanBusy | output | 1 | Walker holds a span |
| reqValid | output | 1 | Line fill request this cycle |
| reqLine | output | 12 | Requested line address |
| fillValid | input | 1 | Fill completion |
| fillLine | input | 12 | Completed line address |
| pixValid | output | 1 | Pixel record valid |
| pixX | output | 11 | Pixel x |
| pixY | output | 11 | Pixel y |
| pixAddr | output | 16 | Pixel texel address |

## Verification
A push and a pop can fall in the same cycle, and both can touch the same line's reference count. A walker miss can also hit a set whose last reference leaves the queue in that same cycle. Both cases are provoked in several ways: hit spans over lines already filled, a span whose addresses step across one set with different tags, and a 600-pixel span on one line that fills the queue and then drains while the walker refills it. They are judged at the ports. The bench checks the exact pixel sequence, the request count and the absence of output gaps against values computed from the span parameters.

// File: rtl/pq_pkg.sv
package pq_pkg;
  parameter int ADDR_W     = 16;
  parameter int LINE_SHIFT = 4;
  parameter int SET_W      = 3;
  parameter int DEPTH      = 512;
  parameter int COORD_W    = 11;
  parameter int LEN_W      = 10;

  localparam int LINE_W = ADDR_W - LINE_SHIFT;
  localparam int TAG_W  = LINE_W - SET_W;
  localparam int SETS   = 1 << SET_W;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {LN_EMPTY, LN_PENDING, LN_READY} lineState_t;

  typedef struct packed {
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
    logic [ADDR_W-1:0]  addr;
  } qEntry_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic req;
  } strobes_t;

  typedef struct packed {
    logic full;
    logic empty;
    logic lookHit;
    logic lookRefZero;
    logic headReady;
  } status_t;
endpackage

// File: rtl/pq_ctrl.sv
module pq_ctrl
  import pq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               spanStart,
  input  logic [COORD_W-1:0] spanX,
  input  logic [COORD_W-1:0] spanY,
  input  logic [LEN_W-1:0]   spanLen,
  input  logic [ADDR_W-1:0]  texBase,
  input  logic [ADDR_W-1:0]  texStep,
  input  status_t            stat,
  output strobes_t           strb,
  output qEntry_t            curEnt,
  output logic               spanBusy
);
  logic               busy;
  logic [COORD_W-1:0] curX, curY;
  logic [ADDR_W-1:0]  curAddr, step;
  logic [LEN_W-1:0]   remain;
  logic               canIssue;

  // A pixel issues when the queue has room and its line is present or replaceable.
  always_comb begin
    canIssue  = busy && !stat.full && (stat.lookHit || stat.lookRefZero);
    strb.push = canIssue;
    strb.req  = canIssue && !stat.lookHit;
    strb.pop  = !stat.empty && stat.headReady;
  end

  assign curEnt   = '{x: curX, y: curY, addr: curAddr};
  assign spanBusy = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      curX    <= '0;
      curY    <= '0;
      curAddr <= '0;
      step    <= '0;
      remain  <= '0;
    end else if (!busy) begin
      if (spanStart && spanLen != '0) begin
        busy    <= 1'b1;
        curX    <= spanX;
        curY    <= spanY;
        curAddr <= texBase;
        step    <= texStep;
        remain  <= spanLen;
      end
    end else if (canIssue) begin
      curX    <= curX + 1'b1;
      curAddr <= curAddr + step;
      remain  <= remain - 1'b1;
      if (remain == LEN_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/pq_dpath.sv
module pq_dpath
  import pq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  qEntry_t            curEnt,
  input  logic               fillValid,
  input  logic [LINE_W-1:0]  fillLine,
  output status_t            stat,
  output logic [LINE_W-1:0]  reqLine,
  output logic               pixValid,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] pixY,
  output logic [ADDR_W-1:0]  pixAddr
);
  qEntry_t          qMem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  lineState_t       lineSt [SETS];
  logic [TAG_W-1:0] lineTag [SETS];
  logic [CNT_W-1:0] refCnt [SETS];

  logic [SET_W-1:0] lookSet, headSet, fillSet;
  logic [TAG_W-1:0] lookTag;
  qEntry_t          head;

  assign lookSet = curEnt.addr[LINE_SHIFT +: SET_W];
  assign lookTag = curEnt.addr[ADDR_W-1 -: TAG_W];
  assign head    = qMem[rdPtr];
  assign headSet = head.addr[LINE_SHIFT +: SET_W];
  assign fillSet = fillLine[SET_W-1:0];
  assign reqLine = curEnt.addr[ADDR_W-1:LINE_SHIFT];

  always_comb begin
    stat.full        = (count == CNT_W'(DEPTH));
    stat.empty       = (count == '0);
    stat.lookHit     = (lineSt[lookSet] != LN_EMPTY) && (lineTag[lookSet] == lookTag);
    stat.lookRefZero = (refCnt[lookSet] == '0);
    stat.headReady   = (lineSt[headSet] == LN_READY);
  end

  // Queue storage and pointers
  always_ff @(posedge clk) begin
    if (strb.push) qMem[wrPtr] <= curEnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CNT_W'(strb.push) - CNT_W'(strb.pop);
    end
  end

  // Line table: state, tag and reference count per set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SETS; i++) begin
        lineSt[i]  <= LN_EMPTY;
        lineTag[i] <= '0;
        refCnt[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < SETS; i++) begin
        if (strb.req && lookSet == SET_W'(i)) begin
          lineSt[i]  <= LN_PENDING;
          lineTag[i] <= lookTag;
        end else if (fillValid && fillSet == SET_W'(i) && lineSt[i] == LN_PENDING) begin
          lineSt[i] <= LN_READY;
        end
        refCnt[i] <= refCnt[i]
                   + CNT_W'(strb.push && lookSet == SET_W'(i))
                   - CNT_W'(strb.pop && headSet == SET_W'(i));
      end
    end
  end

  // Registered pixel output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      pixX     <= '0;
      pixY     <= '0;
      pixAddr  <= '0;
    end else begin
      pixValid <= strb.pop;
      if (strb.pop) begin
        pixX    <= head.x;
        pixY    <= head.y;
        pixAddr <= head.addr;
      end
    end
  end
endmodule

// File: rtl/pq_prefetch_raster.sv
module pq_prefetch_raster
  import pq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               spanStart,
  input  logic [COORD_W-1:0] spanX,
  input  logic [COORD_W-1:0] spanY,
  input  logic [LEN_W-1:0]   spanLen,
  input  logic [ADDR_W-1:0]  texBase,
  input  logic [ADDR_W-1:0]  texStep,
  output logic               spanBusy,
  output logic               reqValid,
  output logic [LINE_W-1:0]  reqLine,
  input  logic               fillValid,
  input  logic [LINE_W-1:0]  fillLine,
  output logic               pixValid,
  output logic [COORD_W-1:0] pixX,
  output logic [COORD_W-1:0] pixY,
  output logic [ADDR_W-1:0]  pixAddr
);
  strobes_t strb;
  status_t  stat;
  qEntry_t  curEnt;

  pq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .spanStart(spanStart), .spanX(spanX), .spanY(spanY),
    .spanLen(spanLen), .texBase(texBase), .texStep(texStep), .stat(stat),
    .strb(strb), .curEnt(curEnt), .spanBusy(spanBusy)
  );

  pq_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .curEnt(curEnt), .fillValid(fillValid),
    .fillLine(fillLine), .stat(stat), .reqLine(reqLine), .pixValid(pixValid),
    .pixX(pixX), .pixY(pixY), .pixAddr(pixAddr)
  );

  assign reqValid = strb.req;
endmodule

// File: rtl/pq_checker.sv
module pq_checker
  import pq_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     spanBusy,
  input logic     reqValid,
  input strobes_t strb,
  input status_t  stat
);
  // R1: an idle walker raises no request
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN) !spanBusy |-> !reqValid);
  // R4: every request goes with a queue push
  p_req_with_push_r4: assert property (@(posedge clk) disable iff (!rstN) strb.req |-> strb.push);
  // R5: a replacement only targets a set with no queued references
  p_no_live_evict_r5: assert property (@(posedge clk) disable iff (!rstN) strb.req |-> stat.lookRefZero);
  // R6: no push into a full queue
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN) stat.full |-> !strb.push);
  // R7: pop only from a non-empty queue
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN) strb.pop |-> !stat.empty);
endmodule

bind pq_prefetch_raster pq_checker i_chk (
  .clk(clk), .rstN(rstN), .spanBusy(spanBusy), .reqValid(reqValid), .strb(strb), .stat(stat)
);

// File: tb/test_pq_prefetch_raster.sv
module test_pq_prefetch_raster;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        spanStart = 1'b0;
  logic [10:0] spanX = '0, spanY = '0;
  logic [9:0]  spanLen = '0;
  logic [15:0] texBase = '0, texStep = '0;
  logic        spanBusy, reqValid, fillValid = 1'b0, pixValid;
  logic [11:0] reqLine, fillLine = '0;
  logic [10:0] pixX, pixY;
  logic [15:0] pixAddr;

  pq_prefetch_raster i_pq_prefetch_raster (
    .clk(clk), .rstN(rstN), .spanStart(spanStart), .spanX(spanX), .spanY(spanY),
    .spanLen(spanLen), .texBase(texBase), .texStep(texStep), .spanBusy(spanBusy),
    .reqValid(reqValid), .reqLine(reqLine), .fillValid(fillValid), .fillLine(fillLine),
    .pixValid(pixValid), .pixX(pixX), .pixY(pixY), .pixAddr(pixAddr)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model: in-order fills after fillDelay cycles
  int fillDelay = 20;
  int mLine [1024];
  int mDue  [1024];
  int mHead = 0, mTail = 0, reqCnt = 0;
  always @(negedge clk) begin
    fillValid = 1'b0;
    if (mHead != mTail && mDue[mHead % 1024] <= cyc) begin
      fillValid = 1'b1;
      fillLine  = 12'(mLine[mHead % 1024]);
      mHead++;
    end
    if (rstN && reqValid) begin
      mLine[mTail % 1024] = int'(reqLine);
      mDue[mTail % 1024]  = cyc + fillDelay;
      mTail++;
      reqCnt++;
    end
  end

  // pixel monitor
  int eX, eY, eBase, eStep, pixCnt = 0, streamErr = 0, gapCnt = 0, lastCyc = 0;
  always @(negedge clk) begin
    if (rstN && pixValid) begin
      if (pixX !== 11'(eX + pixCnt) || pixY !== 11'(eY) || pixAddr !== 16'(eBase + pixCnt * eStep))
        streamErr++;
      if (pixCnt != 0 && lastCyc != cyc - 1) gapCnt++;
      lastCyc = cyc;
      pixCnt++;
    end
  end

  task automatic launch(input int x, y, len, base, step);
    @(negedge clk);
    eX = x; eY = y; eBase = base; eStep = step;
    pixCnt = 0; streamErr = 0; gapCnt = 0; reqCnt = 0;
    spanStart = 1'b1; spanX = 11'(x); spanY = 11'(y); spanLen = 10'(len);
    texBase = 16'(base); texStep = 16'(step);
    @(negedge clk);
    spanStart = 1'b0;
  endtask

  task automatic waitDone(input int len, input string req);
    int t = 0;
    while ((pixCnt < len || spanBusy) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(t < 5000, {req, " span completes"}, t, 5000);
    repeat (5) @(negedge clk);
  endtask

  // stimulus table: x, y, len, base, step, expected requests
  localparam int NV = 5;
  localparam int VX [NV] = '{5, 100, 0, 20, 7};
  localparam int VY [NV] = '{3, 7, 9, 1, 4};
  localparam int VL [NV] = '{40, 40, 3, 16, 4};
  localparam int VB [NV] = '{0, 0, 0, 'h30, 'hFFF8};
  localparam int VS [NV] = '{1, 1, 128, 2, 4};
  localparam int VR [NV] = '{3, 0, 2, 2, 2};

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(spanBusy == 1'b0, "R1 busy", int'(spanBusy), 0);
    check(pixValid == 1'b0, "R1 pixValid", int'(pixValid), 0);
    check(reqValid == 1'b0, "R1 reqValid", int'(reqValid), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R3 stream, R4 request count, R5 same-set conflicts (row 2)
    for (int v = 0; v < NV; v++) begin
      launch(VX[v], VY[v], VL[v], VB[v], VS[v]);
      waitDone(VL[v], "R3");
      check(streamErr == 0, "R3 pixel values", streamErr, 0);
      check(pixCnt == VL[v], "R3 pixel count", pixCnt, VL[v]);
      check(reqCnt == VR[v], "R4 R5 request count", reqCnt, VR[v]);
      if (VR[v] == 0) check(gapCnt == 0, "R8 hit span gaps", gapCnt, 0);
    end

    // R8: filled lines 3 and 4 stream at one pixel per cycle
    launch(50, 2, 32, 'h30, 1);
    waitDone(32, "R8");
    check(gapCnt == 0, "R8 gaps", gapCnt, 0);
    check(reqCnt == 0, "R4 no request on hit", reqCnt, 0);

    // R2: start while busy is ignored
    launch(300, 11, 20, 'h200, 1);
    repeat (2) @(negedge clk);
    spanStart = 1'b1; spanX = 11'd1; spanY = 11'd1; spanLen = 10'd5; texBase = 16'h7000;
    @(negedge clk);
    spanStart = 1'b0;
    waitDone(20, "R2");
    repeat (40) @(negedge clk);
    check(streamErr == 0, "R2 stream intact", streamErr, 0);
    check(pixCnt == 20, "R2 no extra pixels", pixCnt, 20);
    check(reqCnt == 2, "R2 no extra requests", reqCnt, 2);

    // R2: zero length does not start
    @(negedge clk);
    spanStart = 1'b1; spanLen = 10'd0;
    @(negedge clk);
    spanStart = 1'b0;
    @(negedge clk);
    check(spanBusy == 1'b0, "R2 zero length", int'(spanBusy), 0);

    // R6 R7: 600 pixels on one line, fill arrives late
    fillDelay = 700;
    launch(0, 20, 600, 'h500, 0);
    repeat (560) @(negedge clk);
    check(spanBusy == 1'b1, "R6 walker stalled on full queue", int'(spanBusy), 1);
    check(pixCnt == 0, "R7 no pop before fill", pixCnt, 0);
    waitDone(600, "R6");
    check(streamErr == 0, "R6 stream", streamErr, 0);
    check(pixCnt == 600, "R6 count", pixCnt, 600);
    check(gapCnt == 0, "R8 drain gaps", gapCnt, 0);
    check(reqCnt == 1, "R4 single request", reqCnt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule